// File: doc/BRIEF.md
# Sleep Power-Down Sequencer

This block is the state machine that powers a processor domain down and back up around deep sleep. After reset it first asks the processor, through a request/acknowledge pair, to agree that deep sleep will be handled by the external wake controller. Until that agreement arrives, any deep-sleep indication is ignored. The agreement lasts until the next reset.

Once agreement is reached, a deep-sleep indication starts the power-down path. The sequencer drives an active-low hold request so that the processor cannot wake part way through. It waits for the active-low hold acknowledge. It then isolates the domain outputs, enables state retention and removes power, one step after another. A wake request from the wake controller runs the same steps in reverse. The hold is released only after isolation has been removed. A wake request that arrives while power-down is still under way is latched, and power-up starts as soon as power-down has completed.

Each timed step lasts `STEP_CYC` clock cycles, and the default is 1. Every control output comes straight from a flop.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and after reset: `en_req_o`=1, `awake_o`=1, `hold_req_n_o`=1, `iso_n_o`=1, `ret_n_o`=1, `pwr_dn_o`=0.
- R2: While agreement is pending (`en_req_o`=1), `deep_sleep_i` has no effect: every output keeps its value.
- R3: A high `en_ack_i` while agreement is pending clears `en_req_o` at the next edge. After that, `deep_sleep_i`=1 drives `hold_req_n_o` low and `awake_o` low at the next edge.
- R4: While `hold_req_n_o`=0 and `hold_ack_n_i`=1 on the power-down path, isolation is not asserted. Isolation is asserted at the edge after `hold_ack_n_i` is seen low.
- R5: Power-down order: `iso_n_o` falls first. `ret_n_o` falls `STEP_CYC` cycles later. `pwr_dn_o` rises `STEP_CYC` cycles after that.
- R6: With power off, `pwr_dn_o` stays high until a wake is seen. A high `wake_req_i` clears `pwr_dn_o` at the next edge. `ret_n_o` rises `STEP_CYC` cycles later, and `iso_n_o` rises `STEP_CYC` cycles after that.
- R7: `hold_req_n_o` rises `STEP_CYC` cycles after `iso_n_o` rises. `awake_o` returns to 1 at the edge after `hold_ack_n_i` is seen high.
- R8: A `wake_req_i` pulse seen after the hold request and before power-off is remembered. `pwr_dn_o` is then high for exactly one cycle before power-up begins.
- R9: Agreement persists, so a later deep sleep runs the full sequence again without a new enable handshake.
- R10: The controls always nest: `pwr_dn_o`=1 implies `ret_n_o`=0; `ret_n_o`=0 implies `iso_n_o`=0; `iso_n_o`=0 implies `hold_req_n_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sleep_i | input | 1 | Processor reports deep sleep |
| en_ack_i | input | 1 | Processor agrees to wake-controller sleep |
| hold_ack_n_i | input | 1 | Active-low acknowledge of the sleep hold |
| wake_req_i | input | 1 | Wake request from the wake controller |
| en_req_o | output | 1 | Request for wake-controller sleep agreement |
| hold_req_n_o | output | 1 | Active-low request holding the processor asleep |
| iso_n_o | output | 1 | Active-low output isolation |
| ret_n_o | output | 1 | Active-low state retention |
| pwr_dn_o | output | 1 | Active-high power removal |
| awake_o | output | 1 | Domain awake and free to run |

## Verification
The bench sends deep sleep before agreement. A design that skipped the agreement check would start holding the processor and drop `awake_o` at that point. The bench keeps the hold acknowledge withheld for several cycles, which catches a sequencer that isolates before the handshake is done. It also pulses wake in the middle of power-down. A design without the wake latch would then stay powered off forever, and a design that cut the sequence short would never raise `pwr_dn_o`. The step length is set to two cycles so that every step dwells and every step order is checked. A final sleep with a long off period and a late wake catches agreement that is lost after the first round.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_NEGOT,
        ST_READY,
        ST_HOLD,
        ST_ISO,
        ST_RET,
        ST_OFF,
        ST_PWRON,
        ST_UNRET,
        ST_UNISO,
        ST_UNHOLD
    } seq_state_e;

    typedef struct packed {
        logic en_req;
        logic hold_n;
        logic iso_n;
        logic ret_n;
        logic pwr_dn;
        logic awake;
    } ctrl_out_t;

    typedef struct packed {
        seq_state_e state;
        ctrl_out_t  ctl;
    } seq_regs_t;

    function automatic ctrl_out_t ctl_decode(seq_state_e s);
        ctrl_out_t c;
        c.en_req = (s == ST_NEGOT);
        c.awake  = (s == ST_NEGOT) || (s == ST_READY);
        c.hold_n = (s == ST_NEGOT) || (s == ST_READY) || (s == ST_UNHOLD);
        c.iso_n  = c.hold_n || (s == ST_HOLD) || (s == ST_UNISO);
        c.ret_n  = c.iso_n || (s == ST_ISO) || (s == ST_UNRET);
        c.pwr_dn = (s == ST_OFF);
        return c;
    endfunction

endpackage

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
    parameter int STEP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic done_o
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = '0;
        else if (!done_o)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic wake_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i)
            pend_d = 1'b0;
        else if (arm_i && wake_i)
            pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int STEP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic deep_sleep_i,
    input  logic en_ack_i,
    input  logic hold_ack_n_i,
    input  logic wake_req_i,
    output logic en_req_o,
    output logic hold_req_n_o,
    output logic iso_n_o,
    output logic ret_n_o,
    output logic pwr_dn_o,
    output logic awake_o
);
    seq_regs_t r_d, r_q;
    logic      step_done;
    logic      wake_pend;
    logic      wake_arm;
    logic      wake_clr;
    logic      tmr_restart;

    assign wake_arm    = (r_q.state == ST_HOLD) || (r_q.state == ST_ISO) ||
                         (r_q.state == ST_RET)  || (r_q.state == ST_OFF);
    assign wake_clr    = (r_q.state == ST_PWRON);
    assign tmr_restart = (r_d.state != r_q.state);

    pwr_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .done_o    (step_done)
    );

    pwr_wake_latch u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (wake_arm),
        .wake_i (wake_req_i),
        .clr_i  (wake_clr),
        .pend_o (wake_pend)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_NEGOT:  if (en_ack_i)          r_d.state = ST_READY;
            ST_READY:  if (deep_sleep_i)      r_d.state = ST_HOLD;
            ST_HOLD:   if (!hold_ack_n_i)     r_d.state = ST_ISO;
            ST_ISO:    if (step_done)         r_d.state = ST_RET;
            ST_RET:    if (step_done)         r_d.state = ST_OFF;
            ST_OFF:    if (wake_pend || wake_req_i) r_d.state = ST_PWRON;
            ST_PWRON:  if (step_done)         r_d.state = ST_UNRET;
            ST_UNRET:  if (step_done)         r_d.state = ST_UNISO;
            ST_UNISO:  if (step_done)         r_d.state = ST_UNHOLD;
            ST_UNHOLD: if (hold_ack_n_i)      r_d.state = ST_READY;
            default:                          r_d.state = ST_NEGOT;
        endcase
        r_d.ctl = ctl_decode(r_d.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_NEGOT;
            r_q.ctl   <= ctl_decode(ST_NEGOT);
        end else begin
            r_q <= r_d;
        end
    end

    assign en_req_o     = r_q.ctl.en_req;
    assign hold_req_n_o = r_q.ctl.hold_n;
    assign iso_n_o      = r_q.ctl.iso_n;
    assign ret_n_o      = r_q.ctl.ret_n;
    assign pwr_dn_o     = r_q.ctl.pwr_dn;
    assign awake_o      = r_q.ctl.awake;

    // R10
    nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_o || !ret_n_o) && (ret_n_o || !iso_n_o) && (iso_n_o || !hold_req_n_o));

    // R2
    no_sleep_unagreed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req_o && !en_ack_i) |=> (hold_req_n_o && awake_o));

    // R4
    iso_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_n_o) |-> $past(!hold_ack_n_i));

    // R5
    ret_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ret_n_o) |-> $past(!iso_n_o));

    // R5
    pd_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn_o) |-> $past(!ret_n_o));

    // R7
    hold_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req_n_o) |-> $past(iso_n_o));

    // R6
    power_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn_o && !wake_req_i && !wake_pend) |=> pwr_dn_o);

endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
    localparam int PERIOD = 10;
    localparam int STEP   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic deep_sleep = 1'b0;
    logic en_ack = 1'b0;
    logic hold_ack_n = 1'b1;
    logic wake_req = 1'b0;
    logic en_req, hold_req_n, iso_n, ret_n, pwr_dn, awake;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // reference model state
    int  phase = 0;
    int  dwell = 0;
    bit  pend = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(.STEP_CYC(STEP)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .deep_sleep_i (deep_sleep),
        .en_ack_i     (en_ack),
        .hold_ack_n_i (hold_ack_n),
        .wake_req_i   (wake_req),
        .en_req_o     (en_req),
        .hold_req_n_o (hold_req_n),
        .iso_n_o      (iso_n),
        .ret_n_o      (ret_n),
        .pwr_dn_o     (pwr_dn),
        .awake_o      (awake)
    );

    // phases: 0 agreeing, 1 ready, 2 holding, 3 isolated, 4 retained, 5 off,
    // 6 powered, 7 unretained, 8 unisolated, 9 releasing hold
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0; dwell = 0; pend = 1'b0;
        end else begin
            int nxt;
            nxt = phase;
            if (phase >= 2 && phase <= 4 && wake_req) pend = 1'b1;
            case (phase)
                0: if (en_ack) nxt = 1;
                1: if (deep_sleep) nxt = 2;
                2: if (!hold_ack_n) nxt = 3;
                5: if (pend || wake_req) begin nxt = 6; pend = 1'b0; end
                9: if (hold_ack_n) nxt = 1;
                default: begin
                    if (dwell == STEP - 1) nxt = (phase == 8) ? 9 : phase + 1;
                    else dwell++;
                end
            endcase
            if (nxt != phase) dwell = 0;
            phase = nxt;
        end
    end

    task automatic cmp(string nm, logic got, logic exp);
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: %s got %b expected %b (t=%0t)", tag, nm, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            vectors++;
            cmp("en_req",     en_req,     phase == 0);
            cmp("awake",      awake,      phase <= 1);
            cmp("hold_req_n", hold_req_n, phase <= 1 || phase == 9);
            cmp("iso_n",      iso_n,      phase <= 2 || phase >= 8);
            cmp("ret_n",      ret_n,      phase <= 3 || phase >= 7);
            cmp("pwr_dn",     pwr_dn,     phase == 5);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: run did not complete got hung expected done");
        finish_run();
    end

    initial begin
        tag = "R1";
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R2: deep sleep without agreement is ignored
        tag = "R2";
        deep_sleep = 1'b1;
        cyc(5);
        deep_sleep = 1'b0;
        cyc(1);
        // R3: agreement, then deep sleep starts hold
        tag = "R3";
        en_ack = 1'b1;
        cyc(2);
        en_ack = 1'b0;
        cyc(2);
        deep_sleep = 1'b1;
        cyc(2);
        // R4: hold acknowledge withheld
        tag = "R4";
        cyc(4);
        hold_ack_n = 1'b0;
        // R5: power-down ordering
        tag = "R5";
        cyc(4 * STEP + 2);
        // R6: power stays off, then wake
        tag = "R6";
        cyc(5);
        wake_req = 1'b1;
        deep_sleep = 1'b0;
        cyc(1);
        wake_req = 1'b0;
        cyc(4 * STEP + 2);
        // R7: hold release and return to awake
        tag = "R7";
        cyc(2);
        hold_ack_n = 1'b1;
        cyc(3);
        // R8: wake pulse during power-down
        tag = "R8";
        deep_sleep = 1'b1;
        cyc(2);
        hold_ack_n = 1'b0;
        cyc(2);
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        deep_sleep = 1'b0;
        cyc(6 * STEP + 4);
        hold_ack_n = 1'b1;
        cyc(3);
        // R8: wake while hold not yet acknowledged
        deep_sleep = 1'b1;
        cyc(2);
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        hold_ack_n = 1'b0;
        deep_sleep = 1'b0;
        cyc(6 * STEP + 4);
        hold_ack_n = 1'b1;
        cyc(3);
        // R9 / R10: second full round, long off period
        tag = "R9";
        deep_sleep = 1'b1;
        cyc(1);
        hold_ack_n = 1'b0;
        cyc(20);
        deep_sleep = 1'b0;
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        tag = "R10";
        cyc(4 * STEP + 2);
        hold_ack_n = 1'b1;
        cyc(4);
        finish_run();
    end

endmodule